// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This block is a purely combinational datapath for IEEE-754 single-precision values. It evaluates three predicates (equal, less-than, less-or-equal) and two selections (minimum, maximum) on a pair of 32-bit operands. An operation code picks the function. A one-bit predicate result, a 32-bit selected value and an invalid-operation flag are all valid in the same cycle as the inputs.

By default the unit treats any operand with a zero exponent field as a zero of its own sign. This matches a floating-point pipeline that flushes denormals. The parameter `SUB_EN` switches to full ordering of subnormals. Quiet and signalling NaNs follow different flag rules depending on the operation. The two selections use a total order on zeros, so negative zero lies below positive zero.

Top module: `fpcmp_unit`

## Requirements
- R1: With op_i = 0 (equal), cmp_o is 1 exactly when the operands are numerically equal; +0 and -0 are equal.
- R2: With op_i = 1 (less-than) and op_i = 2 (less-or-equal), cmp_o follows numeric order. When both operands are negative, order by magnitude is reversed. Infinities lie at the ends of the order.
- R3: With op_i = 2, cmp_o is 1 when both operands are negative and bit-identical.
- R4: With SUB_EN = 0, an operand whose exponent field (bits 30:23) is zero compares exactly as a zero in all three predicates.
- R5: A NaN is an operand with exponent all ones and a nonzero fraction. When either operand is a NaN, cmp_o is 0 for op_i 0, 1 and 2.
- R6: With op_i = 0, nv_o is 1 only when an operand is a signalling NaN, which is a NaN with fraction bit 22 clear.
- R7: With op_i = 1 or 2, nv_o is 1 when either operand is any NaN.
- R8: op_i = 3 (minimum) and op_i = 4 (maximum) return the lesser or greater operand as it was given. -0 orders below +0. With SUB_EN = 0, subnormals order as zeros of their own sign. When both operands order the same, opa_i is returned.
- R9: For minimum or maximum with exactly one NaN operand, mm_o is the other operand. With two NaN operands, mm_o is 0x7FC00000.
- R10: For minimum and maximum, nv_o is 1 exactly when an operand is a signalling NaN.
- R11: op_i values 5 to 7 give cmp_o = 0, mm_o = 0 and nv_o = 0.
- R12: cmp_o is 0 during minimum and maximum, and mm_o is 0 during the three predicates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand, single precision |
| opb_i | input | 32 | Second operand, single precision |
| op_i | input | 3 | Operation: 0 eq, 1 lt, 2 le, 3 min, 4 max |
| cmp_o | output | 1 | Predicate result |
| mm_o | output | 32 | Selected operand for min/max |
| nv_o | output | 1 | Invalid-operation flag |

## Verification
Several cases are narrow and easy to miss: both operands negative and equal, the two zeros paired, a subnormal set against a zero of the opposite sign, and signalling NaNs set against quiet ones. Purely random operands almost never produce them. The stimulus therefore draws both operands from a small pool that contains every special encoding and pairs it exhaustively under all eight operation codes. A random pass over the same pool then mixes in arbitrary bit patterns.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int W     = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_LE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4
  } fpcmp_op_e;

  typedef struct packed {
    logic         sign;
    logic         is_nan;
    logic         is_snan;
    logic         is_zero;
    logic [W-2:0] mag;
  } fp_info_t;

  localparam logic [W-1:0] CANON_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode
  import fpcmp_pkg::*;
#(
  parameter bit SUB_EN = 1'b0
) (
  input  logic [W-1:0] val_i,
  output fp_info_t     info_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             exp_zero;
  logic             man_nz;
  logic             tiny;

  assign exp_f    = val_i[W-2 -: EXP_W];
  assign man_f    = val_i[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_f;

  // Subnormal handling variant
  generate
    if (SUB_EN) begin : g_sub
      assign tiny = exp_zero & ~man_nz;
    end else begin : g_ftz
      assign tiny = exp_zero;
    end
  endgenerate

  always_comb begin
    info_o.sign    = val_i[W-1];
    info_o.is_nan  = exp_max & man_nz;
    info_o.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];
    info_o.is_zero = tiny;
    info_o.mag     = tiny ? '0 : val_i[W-2:0];
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fp_info_t a_i,
  input  fp_info_t b_i,
  output logic     eq_o,
  output logic     lt_o,
  output logic     slt_ab_o,
  output logic     slt_ba_o
);
  logic mag_lt, mag_gt, mag_eq, both_zero;

  assign mag_lt    = a_i.mag < b_i.mag;
  assign mag_gt    = a_i.mag > b_i.mag;
  assign mag_eq    = a_i.mag == b_i.mag;
  assign both_zero = a_i.is_zero & b_i.is_zero;

  // Total order with signed zeros; negatives reverse magnitude order
  assign slt_ab_o = (a_i.sign & ~b_i.sign)
                  | (~a_i.sign & ~b_i.sign & mag_lt)
                  | (a_i.sign & b_i.sign & mag_gt);
  assign slt_ba_o = (b_i.sign & ~a_i.sign)
                  | (~b_i.sign & ~a_i.sign & mag_gt)
                  | (b_i.sign & a_i.sign & mag_lt);

  // Numeric predicates: zeros of either sign are equal
  assign eq_o = both_zero | ((a_i.sign == b_i.sign) & mag_eq);
  assign lt_o = slt_ab_o & ~both_zero;

  always_comb begin
    p_lt_eq_excl_r2: assert (!(lt_o && eq_o))
      else $error("lt and eq both set");
    p_order_antisym_r8: assert (!(slt_ab_o && slt_ba_o))
      else $error("order not antisymmetric");
  end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
  import fpcmp_pkg::*;
(
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fp_info_t     ai_i,
  input  fp_info_t     bi_i,
  input  logic         slt_ab_i,
  input  logic         slt_ba_i,
  input  logic         take_max_i,
  output logic [W-1:0] res_o
);
  logic pick_b;

  assign pick_b = take_max_i ? slt_ab_i : slt_ba_i;

  always_comb begin
    if (ai_i.is_nan && bi_i.is_nan) res_o = CANON_QNAN;
    else if (ai_i.is_nan)           res_o = b_i;
    else if (bi_i.is_nan)           res_o = a_i;
    else                            res_o = pick_b ? b_i : a_i;
  end

  always_comb begin
    p_sel_operand_r8: assert ((ai_i.is_nan && bi_i.is_nan) || res_o == a_i || res_o == b_i)
      else $error("selection is not an operand");
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter bit SUB_EN = 1'b0
) (
  input  logic [W-1:0]    opa_i,
  input  logic [W-1:0]    opb_i,
  input  logic [OP_W-1:0] op_i,
  output logic            cmp_o,
  output logic [W-1:0]    mm_o,
  output logic            nv_o
);
  localparam int N_OPND = 2;

  logic [W-1:0] opnd [N_OPND];
  fp_info_t     info [N_OPND];
  logic         eq, lt, slt_ab, slt_ba;
  logic         any_nan, any_snan, is_pred, is_sel;
  logic [W-1:0] sel_res;

  assign opnd[0] = opa_i;
  assign opnd[1] = opb_i;

  generate
    for (genvar i = 0; i < N_OPND; i++) begin : g_dec
      fpcmp_decode #(.SUB_EN(SUB_EN)) u_dec (
        .val_i (opnd[i]),
        .info_o(info[i])
      );
    end
  endgenerate

  fpcmp_order u_ord (
    .a_i     (info[0]),
    .b_i     (info[1]),
    .eq_o    (eq),
    .lt_o    (lt),
    .slt_ab_o(slt_ab),
    .slt_ba_o(slt_ba)
  );

  fpcmp_select u_sel (
    .a_i       (opa_i),
    .b_i       (opb_i),
    .ai_i      (info[0]),
    .bi_i      (info[1]),
    .slt_ab_i  (slt_ab),
    .slt_ba_i  (slt_ba),
    .take_max_i(op_i == OP_MAX),
    .res_o     (sel_res)
  );

  assign any_nan  = info[0].is_nan | info[1].is_nan;
  assign any_snan = info[0].is_snan | info[1].is_snan;
  assign is_pred  = (op_i == OP_EQ) | (op_i == OP_LT) | (op_i == OP_LE);
  assign is_sel   = (op_i == OP_MIN) | (op_i == OP_MAX);

  always_comb begin
    cmp_o = 1'b0;
    mm_o  = '0;
    nv_o  = 1'b0;
    case (op_i)
      OP_EQ: begin
        cmp_o = eq & ~any_nan;
        nv_o  = any_snan;
      end
      OP_LT: begin
        cmp_o = lt & ~any_nan;
        nv_o  = any_nan;
      end
      OP_LE: begin
        cmp_o = (lt | eq) & ~any_nan;
        nv_o  = any_nan;
      end
      OP_MIN, OP_MAX: begin
        mm_o = sel_res;
        nv_o = any_snan;
      end
      default: ;
    endcase
  end

  always_comb begin
    p_nan_pred_zero_r5: assert (!(is_pred && any_nan && cmp_o))
      else $error("predicate true with NaN");
    p_eq_quiet_nv_r6: assert (!((op_i == OP_EQ) && !any_snan && nv_o))
      else $error("eq flagged without sNaN");
    p_two_nan_canon_r9: assert (!(is_sel && info[0].is_nan && info[1].is_nan) || mm_o == CANON_QNAN)
      else $error("two NaNs not canonical");
    p_unused_quiet_r11: assert (is_pred || is_sel || (!cmp_o && !nv_o && mm_o == '0))
      else $error("unused op drives outputs");
    p_out_split_r12: assert (!(is_sel && cmp_o) && !(is_pred && mm_o != '0))
      else $error("inactive output nonzero");
  end
endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int N_RAND     = 3000;

  logic        clk;
  logic        rst_n;
  logic [31:0] opa, opb;
  logic [2:0]  op;
  logic        cmp;
  logic [31:0] mm;
  logic        nv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fpcmp_unit u0 (
    .opa_i(opa), .opb_i(opb), .op_i(op),
    .cmp_o(cmp), .mm_o(mm), .nv_o(nv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit f_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit f_snan(input logic [31:0] v);
    return f_nan(v) && !v[22];
  endfunction
  function automatic bit f_zero(input logic [31:0] v);
    return v[30:23] == 8'h00;
  endfunction
  function automatic longint f_num(input logic [31:0] v);
    longint m;
    m = f_zero(v) ? 0 : longint'({33'd0, v[30:0]});
    return v[31] ? -m : m;
  endfunction
  function automatic longint f_tot(input logic [31:0] v);
    longint m;
    m = f_zero(v) ? 0 : longint'({33'd0, v[30:0]});
    return v[31] ? -(2*m+1) : (2*m+1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] o);
    bit          e_cmp, e_nv, an;
    logic [31:0] e_mm;
    string       tc, tn, tm;
    @(posedge clk);
    opa = a; opb = b; op = o;
    an = f_nan(a) || f_nan(b);
    e_cmp = 0; e_nv = 0; e_mm = 32'h0;
    case (o)
      3'd0: begin e_cmp = !an && f_num(a) == f_num(b); e_nv = f_snan(a) || f_snan(b); end
      3'd1: begin e_cmp = !an && f_num(a) <  f_num(b); e_nv = an; end
      3'd2: begin e_cmp = !an && f_num(a) <= f_num(b); e_nv = an; end
      3'd3, 3'd4: begin
        e_nv = f_snan(a) || f_snan(b);
        if (f_nan(a) && f_nan(b)) e_mm = 32'h7FC00000;
        else if (f_nan(a))        e_mm = b;
        else if (f_nan(b))        e_mm = a;
        else if (o == 3'd3)       e_mm = (f_tot(b) < f_tot(a)) ? b : a;
        else                      e_mm = (f_tot(b) > f_tot(a)) ? b : a;
      end
      default: ;
    endcase
    if (o > 3'd4)                        tc = "R11";
    else if (o >= 3'd3)                  tc = "R12";
    else if (an)                         tc = "R5";
    else if (f_zero(a) || f_zero(b))     tc = (a[22:0] != 0 || b[22:0] != 0) ? "R4" : "R1";
    else if (o == 3'd2 && a[31] && a == b) tc = "R3";
    else if (o == 3'd0)                  tc = "R1";
    else                                 tc = "R2";
    if (o > 3'd4)       tn = "R11";
    else if (o == 3'd0) tn = "R6";
    else if (o <= 3'd2) tn = "R7";
    else                tn = "R10";
    if (o > 3'd4)       tm = "R11";
    else if (o <= 3'd2) tm = "R12";
    else if (an)        tm = "R9";
    else                tm = "R8";
    @(negedge clk);
    check(tc, {31'd0, cmp}, {31'd0, e_cmp});
    check(tn, {31'd0, nv},  {31'd0, e_nv});
    check(tm, mm, e_mm);
  endtask

  logic [31:0] pool [16];

  initial begin
    pool[0]  = 32'h00000000; pool[1]  = 32'h80000000;
    pool[2]  = 32'h3F800000; pool[3]  = 32'hBF800000;
    pool[4]  = 32'h40000000; pool[5]  = 32'hC0000000;
    pool[6]  = 32'h00000001; pool[7]  = 32'h80400000;
    pool[8]  = 32'h7FC00000; pool[9]  = 32'h7F800001;
    pool[10] = 32'hFFC00001; pool[11] = 32'h7F800000;
    pool[12] = 32'hFF800000; pool[13] = 32'h7F7FFFFF;
    pool[14] = 32'hBFC00000; pool[15] = 32'h00800000;
    rst_n = 1'b0; opa = 0; opb = 0; op = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: equal zeros, eq op
    check("R1", {31'd0, cmp}, 32'd1);
    check("R6", {31'd0, nv}, 32'd0);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(pool[i], pool[j], 3'(o));
    for (int k = 0; k < N_RAND; k++) begin
      logic [31:0] ra, rb;
      ra = ($urandom % 2) ? pool[$urandom % 16] : $urandom;
      rb = ($urandom % 3 == 0) ? ra : (($urandom % 2) ? pool[$urandom % 16] : $urandom);
      if ($urandom % 4 == 0) rb[31] = 1'b1;
      apply(ra, rb, 3'($urandom % 8));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule